// File: doc/BRIEF.md
# Nonuniform Partition Address Generator

This block turns a 15-bit signed fixed-point sample into the two values that a first-order table interpolator needs. The first is a 9-bit address into a 512-entry table of stored samples. The second is a fractional difference that gives the distance from that stored sample to the input. The stored samples are not evenly spaced. The input domain is cut into up to eight regions, and each region has its own sample spacing. A plain high/low bit split of the input therefore cannot produce the address.

The block works in two steps. First it compares the input with a programmable list of region upper limits, which yields a region index. That index then selects six per-region settings: the upper limit itself, a displacement, an address offset, a count of high input bits to take, a count of low sum bits to keep, and a count of low input bits that form the difference.

The address branch takes the selected number of high input bits, adds the displacement, masks the sum to the selected number of low bits, and adds the offset. The difference branch takes the selected number of low input bits and left-aligns them into an unsigned fraction. A region marked as full resolution produces a zero difference. Software can rewrite any setting at run time through a single-word write port, so the same datapath can serve many functions and sample distributions.

Top module: `nupag_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears `addr_o` and `diff_o` to zero. It sets every region limit to the largest positive input (16383) and every other setting to zero. Afterwards every input maps to address 0 and difference 0.
- R2: The region index is the lowest index whose limit, read as a signed 15-bit value, is greater than or equal to the input. An input equal to a limit belongs to that limit's region.
- R3: An input above every limit of regions 0 to 6 falls into region 7, whatever region 7's own limit holds.
- R4: Let `h` be the high-bit count. The high part is the unsigned 15-bit input shifted right by 15−h, or 0 when h=0. The displacement is added to it modulo 2^16. Of that sum, only the low `k` bits are kept, where `k` is the keep count.
- R5: The address is the kept value plus the region offset, modulo 512.
- R6: With a fraction count L from 1 to 15, `diff_o` equals the low L input bits shifted left by 15−L. This forms an unsigned fraction with the binary point above bit 14.
- R7: A region whose fraction count is 0 is a full-resolution region, and its `diff_o` is zero for every input.
- R8: `addr_o` and `diff_o` for an input sampled at one rising edge appear together after that edge. Inputs presented on consecutive cycles give results on consecutive cycles.
- R9: A write is presented with `cfg_we_i` high. It targets the region `cfg_region_i` and the field `cfg_field_i`. Field codes: 0 = limit (data bits 14:0), 1 = displacement (16 bits), 2 = offset (bits 8:0), 3 = high-bit count, 4 = keep count, 5 = fraction count (each count in bits 3:0). A sample taken in the same cycle as the write still uses the old setting. The next sample uses the new one.
- R10: A write with field code 6 or 7 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| x_i | input | 15 | Signed fixed-point input sample |
| cfg_we_i | input | 1 | Setting write enable |
| cfg_region_i | input | 3 | Region targeted by the write |
| cfg_field_i | input | 3 | Field code of the write |
| cfg_data_i | input | 16 | Write data |
| addr_o | output | 9 | Registered table address |
| diff_o | output | 15 | Registered unsigned fractional difference |

## Verification
The bench builds the block with its default parameters: eight regions, a 15-bit input, a 9-bit address, and 4-bit counts. With these defaults the extremes of the input range, ties with every limit, and an empty high slice (count 0) can all be reached. So can a full 15-bit slice, displacement sums that wrap past 2^16, and offset sums that wrap past 511. A region set to full resolution, writes made in the same cycle as a sample, and writes with the unused field codes all lie within this configuration as well. A behavioural model built on integers predicts both outputs on every sampled cycle.

// File: rtl/nupag_pkg.sv
package nupag_pkg;

    // Field codes used by the run-time setting write port.
    typedef enum logic [2:0] {
        FLD_LIMIT    = 3'd0,
        FLD_DISP     = 3'd1,
        FLD_OFFSET   = 3'd2,
        FLD_HI_CNT   = 3'd3,
        FLD_KEEP_CNT = 3'd4,
        FLD_FRAC_CNT = 3'd5
    } cfg_field_e;

endpackage

// File: rtl/nupag_param_bank.sv
module nupag_param_bank
    import nupag_pkg::*;
#(
    parameter int DATA_W      = 15,
    parameter int ADDR_W      = 9,
    parameter int NUM_REGIONS = 8,
    localparam int REG_W      = $clog2(NUM_REGIONS),
    localparam int CNT_W      = $clog2(DATA_W + 1),
    localparam int SUM_W      = DATA_W + 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we_i,
    input  logic [REG_W-1:0]                   cfg_region_i,
    input  logic [2:0]                         cfg_field_i,
    input  logic [SUM_W-1:0]                   cfg_data_i,
    input  logic [REG_W-1:0]                   sel_i,
    output logic [NUM_REGIONS-1:0][DATA_W-1:0] limits_o,
    output logic [SUM_W-1:0]                   disp_o,
    output logic [ADDR_W-1:0]                  offset_o,
    output logic [CNT_W-1:0]                   hi_cnt_o,
    output logic [CNT_W-1:0]                   keep_cnt_o,
    output logic [CNT_W-1:0]                   frac_cnt_o
);

    localparam logic [DATA_W-1:0] LIMIT_RST = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] lim_q   [NUM_REGIONS];
    logic [SUM_W-1:0]  disp_q  [NUM_REGIONS];
    logic [ADDR_W-1:0] off_q   [NUM_REGIONS];
    logic [CNT_W-1:0]  hi_q    [NUM_REGIONS];
    logic [CNT_W-1:0]  keep_q  [NUM_REGIONS];
    logic [CNT_W-1:0]  frac_q  [NUM_REGIONS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                lim_q[i]  <= LIMIT_RST;
                disp_q[i] <= '0;
                off_q[i]  <= '0;
                hi_q[i]   <= '0;
                keep_q[i] <= '0;
                frac_q[i] <= '0;
            end
        end else if (cfg_we_i) begin
            unique case (cfg_field_i)
                FLD_LIMIT:    lim_q[cfg_region_i]  <= cfg_data_i[DATA_W-1:0];
                FLD_DISP:     disp_q[cfg_region_i] <= cfg_data_i;
                FLD_OFFSET:   off_q[cfg_region_i]  <= cfg_data_i[ADDR_W-1:0];
                FLD_HI_CNT:   hi_q[cfg_region_i]   <= cfg_data_i[CNT_W-1:0];
                FLD_KEEP_CNT: keep_q[cfg_region_i] <= cfg_data_i[CNT_W-1:0];
                FLD_FRAC_CNT: frac_q[cfg_region_i] <= cfg_data_i[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lim_out
        assign limits_o[g] = lim_q[g];
    end

    assign disp_o     = disp_q[sel_i];
    assign offset_o   = off_q[sel_i];
    assign hi_cnt_o   = hi_q[sel_i];
    assign keep_cnt_o = keep_q[sel_i];
    assign frac_cnt_o = frac_q[sel_i];

    // A limit write is visible in the stored limit one cycle later (R9)
    assert_limit_write_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we_i && cfg_field_i == FLD_LIMIT)
        |=> limits_o[$past(cfg_region_i)] == $past(cfg_data_i[DATA_W-1:0]))
        else $error("limit write not stored");

endmodule

// File: rtl/nupag_region_find.sv
module nupag_region_find #(
    parameter int DATA_W      = 15,
    parameter int NUM_REGIONS = 8,
    localparam int REG_W      = $clog2(NUM_REGIONS)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [DATA_W-1:0]                  x_i,
    input  logic [NUM_REGIONS-1:0][DATA_W-1:0] limits_i,
    output logic [REG_W-1:0]                   sel_o
);

    logic [NUM_REGIONS-1:0] at_or_below;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        assign at_or_below[g] = $signed(x_i) <= $signed(limits_i[g]);
    end

    // Lowest matching index wins; the last region catches everything else.
    always_comb begin
        sel_o = REG_W'(NUM_REGIONS - 1);
        for (int i = NUM_REGIONS - 2; i >= 0; i--) begin
            if (at_or_below[i]) sel_o = REG_W'(i);
        end
    end

    always @(posedge clk) begin
        if (!rst) begin
            if (sel_o != REG_W'(NUM_REGIONS - 1)) begin
                assert_region_upper_R2: assert ($signed(limits_i[sel_o]) >= $signed(x_i))
                    else $error("input above selected limit");
            end
            if (sel_o != '0) begin
                assert_region_lower_R2: assert ($signed(limits_i[sel_o - REG_W'(1)]) < $signed(x_i))
                    else $error("lower region also matches");
            end
        end
    end

endmodule

// File: rtl/nupag_addr_path.sv
module nupag_addr_path #(
    parameter int DATA_W = 15,
    parameter int ADDR_W = 9,
    localparam int CNT_W = $clog2(DATA_W + 1),
    localparam int SUM_W = DATA_W + 1
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [CNT_W-1:0]  hi_cnt_i,
    input  logic [SUM_W-1:0]  disp_i,
    input  logic [CNT_W-1:0]  keep_cnt_i,
    input  logic [ADDR_W-1:0] offset_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [CNT_W-1:0]  drop_cnt;
    logic [DATA_W-1:0] hi_part;
    logic [SUM_W-1:0]  disp_sum;
    logic [SUM_W-1:0]  keep_mask;
    logic [SUM_W-1:0]  kept;

    always_comb begin
        drop_cnt  = CNT_W'(DATA_W) - hi_cnt_i;
        hi_part   = (hi_cnt_i == '0) ? '0 : (x_i >> drop_cnt);
        disp_sum  = SUM_W'(hi_part) + disp_i;
        keep_mask = (SUM_W'(1) << keep_cnt_i) - SUM_W'(1);
        kept      = disp_sum & keep_mask;
        addr_o    = ADDR_W'(kept) + offset_i;
    end

endmodule

// File: rtl/nupag_diff_path.sv
module nupag_diff_path #(
    parameter int DATA_W = 15,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] x_i,
    input  logic [CNT_W-1:0]  frac_cnt_i,
    output logic [DATA_W-1:0] diff_o
);

    logic [CNT_W-1:0]  pad_cnt;
    logic [DATA_W-1:0] low_mask;

    always_comb begin
        pad_cnt  = CNT_W'(DATA_W) - frac_cnt_i;
        low_mask = (DATA_W'(1) << frac_cnt_i) - DATA_W'(1);
        if (frac_cnt_i == '0) begin
            diff_o = '0;                       // full-resolution region
        end else begin
            diff_o = (x_i & low_mask) << pad_cnt;
        end
    end

endmodule

// File: rtl/nupag_addr_gen.sv
module nupag_addr_gen #(
    parameter int DATA_W      = 15,
    parameter int ADDR_W      = 9,
    parameter int NUM_REGIONS = 8,
    localparam int REG_W      = $clog2(NUM_REGIONS),
    localparam int CNT_W      = $clog2(DATA_W + 1),
    localparam int SUM_W      = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] x_i,
    input  logic              cfg_we_i,
    input  logic [REG_W-1:0]  cfg_region_i,
    input  logic [2:0]        cfg_field_i,
    input  logic [SUM_W-1:0]  cfg_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] diff_o
);

    logic [NUM_REGIONS-1:0][DATA_W-1:0] limits;
    logic [REG_W-1:0]  sel;
    logic [SUM_W-1:0]  disp;
    logic [ADDR_W-1:0] offset;
    logic [CNT_W-1:0]  hi_cnt;
    logic [CNT_W-1:0]  keep_cnt;
    logic [CNT_W-1:0]  frac_cnt;
    logic [ADDR_W-1:0] addr_c;
    logic [DATA_W-1:0] diff_c;

    nupag_param_bank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS)
    ) u_bank (
        .clk(clk), .rst(rst),
        .cfg_we_i(cfg_we_i), .cfg_region_i(cfg_region_i),
        .cfg_field_i(cfg_field_i), .cfg_data_i(cfg_data_i),
        .sel_i(sel), .limits_o(limits),
        .disp_o(disp), .offset_o(offset),
        .hi_cnt_o(hi_cnt), .keep_cnt_o(keep_cnt), .frac_cnt_o(frac_cnt)
    );

    nupag_region_find #(
        .DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS)
    ) u_find (
        .clk(clk), .rst(rst), .x_i(x_i), .limits_i(limits), .sel_o(sel)
    );

    nupag_addr_path #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_addr (
        .x_i(x_i), .hi_cnt_i(hi_cnt), .disp_i(disp),
        .keep_cnt_i(keep_cnt), .offset_i(offset), .addr_o(addr_c)
    );

    nupag_diff_path #(
        .DATA_W(DATA_W)
    ) u_diff (
        .x_i(x_i), .frac_cnt_i(frac_cnt), .diff_o(diff_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            diff_o <= '0;
        end else begin
            addr_o <= addr_c;
            diff_o <= diff_c;
        end
    end

    // Full-resolution region gives zero difference one cycle later (R7)
    assert_full_res_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (frac_cnt == '0) |=> (diff_o == '0))
        else $error("nonzero difference in full-resolution region");

    // Same input and no setting change keeps the address steady (R8)
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_we_i) && x_i == $past(x_i))
        |=> $stable(addr_o))
        else $error("address changed without cause");

endmodule

// File: tb/nupag_addr_gen_tb.sv
module nupag_addr_gen_tb;

    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [14:0] x_i;
    logic        cfg_we_i;
    logic [2:0]  cfg_region_i;
    logic [2:0]  cfg_field_i;
    logic [15:0] cfg_data_i;
    logic [8:0]  addr_o;
    logic [14:0] diff_o;

    int n_checks = 0;
    int n_fail   = 0;

    int m_lim  [NR];
    int m_disp [NR];
    int m_off  [NR];
    int m_hi   [NR];
    int m_keep [NR];
    int m_frac [NR];

    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;   // 50 MHz

    nupag_addr_gen u_dut (
        .clk(clk), .rst(rst), .x_i(x_i),
        .cfg_we_i(cfg_we_i), .cfg_region_i(cfg_region_i),
        .cfg_field_i(cfg_field_i), .cfg_data_i(cfg_data_i),
        .addr_o(addr_o), .diff_o(diff_o)
    );

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin
            m_lim[i] = 16383; m_disp[i] = 0; m_off[i] = 0;
            m_hi[i] = 0; m_keep[i] = 0; m_frac[i] = 0;
        end
    endtask

    function automatic int pick_region(input int x);
        for (int i = 0; i < NR - 1; i++) begin
            if (m_lim[i] >= x) return i;
        end
        return NR - 1;
    endfunction

    task automatic predict(input int x, output int ea, output int ed);
        int r, ux, hi, sum, kept;
        r    = pick_region(x);
        ux   = x & 32'h7FFF;
        hi   = (m_hi[r] == 0) ? 0 : ux / (1 << (15 - m_hi[r]));
        sum  = (hi + m_disp[r]) % 65536;
        kept = sum % (1 << m_keep[r]);
        ea   = (kept + m_off[r]) % 512;
        ed   = (m_frac[r] == 0) ? 0 : (ux % (1 << m_frac[r])) * (1 << (15 - m_frac[r]));
    endtask

    task automatic check(input string tag, input int ea, input int ed);
        n_checks += 2;
        if (int'(addr_o) != ea) begin
            n_fail++;
            $display("FAIL %s addr actual=%0d expected=%0d", tag, addr_o, ea);
        end
        if (int'(diff_o) != ed) begin
            n_fail++;
            $display("FAIL %s diff actual=%0d expected=%0d", tag, diff_o, ed);
        end
    endtask

    // Drive at the falling edge, check at the next falling edge.
    task automatic sample(input string tag, input int x);
        int ea, ed;
        x_i = 15'(x);
        predict(x, ea, ed);
        @(negedge clk);
        check(tag, ea, ed);
    endtask

    task automatic model_write(input int r, input int f, input int v);
        case (f)
            0: begin m_lim[r] = v & 32'h7FFF; if (m_lim[r] > 16383) m_lim[r] -= 32768; end
            1: m_disp[r] = v & 32'hFFFF;
            2: m_off[r]  = v & 32'h1FF;
            3: m_hi[r]   = v & 32'hF;
            4: m_keep[r] = v & 32'hF;
            5: m_frac[r] = v & 32'hF;
            default: ;
        endcase
    endtask

    // Write and sample in the same cycle: the sample sees the old setting.
    task automatic write_sample(input string tag, input int r, input int f, input int v, input int x);
        int ea, ed;
        cfg_we_i = 1'b1; cfg_region_i = 3'(r); cfg_field_i = 3'(f); cfg_data_i = 16'(v);
        x_i = 15'(x);
        predict(x, ea, ed);
        @(negedge clk);
        cfg_we_i = 1'b0;
        model_write(r, f, v);
        check(tag, ea, ed);
    endtask

    task automatic cfg_region(input int r, input int lim, input int disp, input int off,
                              input int hi, input int keep, input int frac);
        write_sample("R9", r, 0, lim, 0);
        write_sample("R9", r, 1, disp, 0);
        write_sample("R9", r, 2, off, 0);
        write_sample("R9", r, 3, hi, 0);
        write_sample("R9", r, 4, keep, 0);
        write_sample("R9", r, 5, frac, 0);
    endtask

    function automatic int next_x();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 9) % 32768) - 16384;
    endfunction

    initial begin
        #(20ns * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int lims [NR] = '{-12000, -4000, -1000, 0, 999, 3999, 11999, 16383};
        rst = 1'b1; x_i = '0; cfg_we_i = 1'b0; cfg_region_i = '0;
        cfg_field_i = '0; cfg_data_i = '0;
        model_reset();
        @(negedge clk); @(negedge clk);
        check("R1 in reset", 0, 0);
        x_i = 15'(12345);
        @(negedge clk);
        check("R1 in reset", 0, 0);
        rst = 1'b0;
        sample("R1", 12345);
        sample("R1", -16384);
        sample("R1", 16383);

        // Program eight regions; region 3 is full resolution (R7).
        cfg_region(0, lims[0], 16'hFFF0, 500, 6, 9, 9);
        cfg_region(1, lims[1], 40,       64,  8, 8, 7);
        cfg_region(2, lims[2], 16'h8000, 130, 9, 7, 6);
        cfg_region(3, lims[3], 1000,     300, 15, 9, 0);
        cfg_region(4, lims[4], 7,        311, 10, 6, 5);
        cfg_region(5, lims[5], 300,      400, 9, 8, 6);
        cfg_region(6, lims[6], 2,        450, 8, 5, 7);
        cfg_region(7, lims[7], 16'hFFFF, 511, 0, 15, 15);

        // Ties and neighbours of every limit (R2).
        for (int i = 0; i < NR - 1; i++) begin
            sample("R2 at limit", lims[i]);
            sample("R2 above limit", lims[i] + 1);
            sample("R2 below limit", lims[i] - 1);
        end
        sample("R2 minimum", -16384);

        // Last region catches everything above (R3).
        write_sample("R3", 7, 0, 12000, 0);
        sample("R3", 12001);
        sample("R3", 16383);
        write_sample("R3", 7, 0, 16'h4000, 0);  // -16384 as limit of the last region
        sample("R3", 14000);

        // Slice, displacement wrap and keep mask (R4), offset wrap (R5).
        sample("R4 disp wrap", -16384);
        sample("R4 disp wrap", -12500);
        sample("R5 offset wrap", -12001);
        sample("R5 offset wrap", 16000);

        // Difference alignment (R6) and full-resolution region (R7).
        sample("R6", -3000);
        sample("R6", 1500);
        sample("R6", 10000);
        for (int v = -999; v <= 0; v += 111) sample("R7 full res", v);

        // Back-to-back samples on consecutive cycles (R8).
        for (int n = 0; n < 400; n++) sample("R8 stream", next_x());

        // Same-cycle write sees the old value, next sample the new (R9).
        write_sample("R9 old value", 4, 2, 17, 500);
        sample("R9 new value", 500);
        write_sample("R9 old value", 4, 5, 0, 600);
        sample("R9 new value", 600);
        write_sample("R9 old value", 1, 0, -2000, -2500);
        sample("R9 new value", -2500);

        // Unused field codes change nothing (R10).
        write_sample("R10", 5, 6, 16'hFFFF, 2000);
        write_sample("R10", 5, 7, 16'hFFFF, 2000);
        sample("R10", 2000);
        sample("R10", 3999);

        for (int n = 0; n < 100; n++) sample("R4 random", next_x());

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule